// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

The scheduler produces row-refresh requests for a DRAM command sequencer so that every row is refreshed within a retention window set at run time. The window is given in clock cycles. Software reprograms it when the clock frequency changes, and may always shorten it to refresh faster. Two styles are offered. In burst style all rows fall due together once per window and are requested back to back. In spread style one row falls due every `window / rows` cycles, so requests are spaced evenly across the window.

Settings can be rewritten while refresh runs. A new window, row count or style is taken over only when the acknowledge for the last row of a pass arrives, or at any time while refresh is switched off. A pass that is in progress is therefore never cut short. Switching refresh off stops all requests, which allows retention experiments. Owed refreshes are counted, so requests that fall due while the sequencer is busy are issued later.

Top module: `rfsh_sched`

## Requirements
- R1: After reset `req_valid` is 0, `req_row` is 0, `stat_owed` is 0 and `stat_mode` is 0.
- R2: Burst style (`cfg_mode` = 0): in the first enabled cycle `stat_owed` is set to the active row count. After that it is set to the row count again every `window` cycles. Rows are requested in ascending order, one per acknowledged cycle.
- R3: Spread style (`cfg_mode` = 1): one refresh falls due every `max(1, window / rows)` cycles, using integer division. Each one raises `stat_owed` by one.
- R4: In spread style `stat_owed` never rises above 8. A refresh that falls due while 8 are owed is dropped.
- R5: `req_valid` is high while refresh is enabled and `stat_owed` is non-zero. It stays high with `req_row` stable until `req_ack` is seen. Each acknowledge lowers `stat_owed` by one and moves `req_row` to the next row, wrapping from `rows - 1` to 0.
- R6: While refresh is enabled, new `cfg_window`, `cfg_rows` and `cfg_mode` values take effect only in the cycle that acknowledges the last row. `stat_mode` shows the active style. The window timer is not restarted when the settings change.
- R7: While `cfg_enable` is 0, `req_valid` is 0, `req_row` holds its value and `stat_owed` is cleared.
- R8: When `cfg_enable` rises, `req_row` restarts at 0 and the window timer restarts.
- R9: A `cfg_rows` or `cfg_window` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Refresh enable |
| cfg_mode | input | 1 | 0 burst style, 1 spread style |
| cfg_window | input | WIN_W | Retention window in clock cycles |
| cfg_rows | input | ROW_W | Number of rows to refresh |
| req_valid | output | 1 | Refresh request to the sequencer |
| req_row | output | ROW_W | Row to refresh |
| req_ack | input | 1 | Sequencer accepts the request |
| stat_mode | output | 1 | Style currently in force |
| stat_owed | output | ROW_W | Refreshes owed but not yet acknowledged |

## Verification
The hardest situation to reach is a setting change that is held back, so that it waits for the last-row acknowledge. A further case is the spread-style counter stuck at its ceiling of 8. Both need a stalled sequencer for many window periods, while the style or window is rewritten mid-pass. Directed phases hold `req_ack` low until the counter saturates, then rewrite the style and release acknowledges one at a time around the wrap. A seeded random phase then mixes stall patterns, row counts including zero, short windows and enable drops against a cycle model in the bench.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic {
        RF_BURST  = 1'b0,
        RF_SPREAD = 1'b1
    } rf_mode_e;
endpackage

// File: rtl/rfsh_cfg.sv
// Cleans up the raw settings and derives the spread-style request gap.
module rfsh_cfg #(
    parameter int WIN_W = 24,
    parameter int ROW_W = 14
) (
    input  logic [WIN_W-1:0] win_i,
    input  logic [ROW_W-1:0] rows_i,
    output logic [WIN_W-1:0] win_o,
    output logic [ROW_W-1:0] rows_o,
    output logic [WIN_W-1:0] gap_o
);
    localparam int PAD_W = WIN_W - ROW_W;

    logic [WIN_W-1:0] rows_ext;
    logic [WIN_W-1:0] quot;

    always_comb begin
        win_o    = (win_i == '0) ? WIN_W'(1) : win_i;
        rows_o   = (rows_i == '0) ? ROW_W'(1) : rows_i;
        rows_ext = {{PAD_W{1'b0}}, rows_o};
        quot     = win_o / rows_ext;
        gap_o    = (quot == '0) ? WIN_W'(1) : quot;
    end
endmodule

// File: rtl/rfsh_pace.sv
// Free-running period timer; pulses tick once every 'period' running cycles.
module rfsh_pace #(
    parameter int WIN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [WIN_W-1:0] period,
    output logic             tick
);
    typedef struct packed {
        logic [WIN_W-1:0] cnt;
    } pace_t;

    pace_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.cnt >= (period - WIN_W'(1)));
        if (!run)
            st_d.cnt = '0;
        else if (tick)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + WIN_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/rfsh_owed.sv
// Owed-refresh counter and row pointer, with the request handshake.
module rfsh_owed
    import rfsh_pkg::*;
#(
    parameter int ROW_W    = 14,
    parameter int PEND_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  rf_mode_e         mode,
    input  logic [ROW_W-1:0] rows,
    input  logic             tick,
    input  logic             ack,
    output logic             req_valid,
    output logic [ROW_W-1:0] row,
    output logic [ROW_W-1:0] owed,
    output logic             wrap
);
    localparam logic [ROW_W-1:0] CAP = ROW_W'(PEND_MAX);

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] owe;
    } owed_t;

    owed_t st_q, st_d;
    logic  fire;
    logic  last;

    always_comb begin
        st_d      = st_q;
        req_valid = run && (st_q.owe != '0);
        fire      = req_valid && ack;
        last      = (st_q.row == (rows - ROW_W'(1)));
        wrap      = fire && last;

        if (start) begin
            st_d.row = '0;
            st_d.owe = (mode == RF_BURST) ? rows : '0;
        end else if (!run) begin
            st_d.owe = '0;
        end else begin
            if (fire)
                st_d.row = last ? '0 : st_q.row + ROW_W'(1);
            if (mode == RF_BURST) begin
                if (tick)
                    st_d.owe = rows;
                else if (fire)
                    st_d.owe = st_q.owe - ROW_W'(1);
            end else begin
                if (tick && !fire)
                    st_d.owe = (st_q.owe >= CAP) ? st_q.owe : st_q.owe + ROW_W'(1);
                else if (fire && !tick)
                    st_d.owe = st_q.owe - ROW_W'(1);
            end
        end
        row  = st_q.row;
        owed = st_q.owe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/rfsh_sched.sv
// Top: holds the active settings and loads them only at a safe boundary.
module rfsh_sched
    import rfsh_pkg::*;
#(
    parameter int WIN_W    = 24,
    parameter int ROW_W    = 14,
    parameter int PEND_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic             cfg_mode,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic [ROW_W-1:0] cfg_rows,
    output logic             req_valid,
    output logic [ROW_W-1:0] req_row,
    input  logic             req_ack,
    output logic             stat_mode,
    output logic [ROW_W-1:0] stat_owed
);
    typedef struct packed {
        logic             en;
        rf_mode_e         mode;
        logic [WIN_W-1:0] win;
        logic [ROW_W-1:0] rows;
        logic [WIN_W-1:0] gap;
    } act_t;

    act_t             st_q, st_d;
    logic [WIN_W-1:0] new_win, new_gap, period;
    logic [ROW_W-1:0] new_rows;
    logic             run, start, tick, wrap;

    rfsh_cfg #(.WIN_W(WIN_W), .ROW_W(ROW_W)) u_cfg (
        .win_i (cfg_window),
        .rows_i(cfg_rows),
        .win_o (new_win),
        .rows_o(new_rows),
        .gap_o (new_gap)
    );

    always_comb begin
        start  = cfg_enable && !st_q.en;
        run    = cfg_enable && st_q.en;
        period = (st_q.mode == RF_SPREAD) ? st_q.gap : st_q.win;

        st_d    = st_q;
        st_d.en = cfg_enable;
        if (!cfg_enable || wrap) begin
            st_d.mode = rf_mode_e'(cfg_mode);
            st_d.win  = new_win;
            st_d.rows = new_rows;
            st_d.gap  = new_gap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= 1'b0;
            st_q.mode <= RF_BURST;
            st_q.win  <= WIN_W'(1);
            st_q.rows <= ROW_W'(1);
            st_q.gap  <= WIN_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    rfsh_pace #(.WIN_W(WIN_W)) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .period(period),
        .tick  (tick)
    );

    rfsh_owed #(.ROW_W(ROW_W), .PEND_MAX(PEND_MAX)) u_owed (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .start    (start),
        .mode     (st_q.mode),
        .rows     (st_q.rows),
        .tick     (tick),
        .ack      (req_ack),
        .req_valid(req_valid),
        .row      (req_row),
        .owed     (stat_owed),
        .wrap     (wrap)
    );

    assign stat_mode = st_q.mode;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
    parameter int ROW_W    = 14,
    parameter int PEND_MAX = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic             req_valid,
    input logic             req_ack,
    input logic [ROW_W-1:0] req_row,
    input logic             stat_mode,
    input logic [ROW_W-1:0] stat_owed
);
    p_no_req_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |-> !req_valid);

    p_row_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> $stable(req_row));

    p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ack) |=> (!cfg_enable || (req_valid && $stable(req_row))));

    p_row_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ack) |=> (req_row == ($past(req_row) + ROW_W'(1)) || req_row == '0));

    p_owed_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_mode && stat_owed >= ROW_W'(PEND_MAX)) |=> (!stat_mode || stat_owed <= $past(stat_owed)));

    p_mode_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_enable && !(req_valid && req_ack)) |=> $stable(stat_mode));
endmodule

bind rfsh_sched rfsh_sched_chk #(.ROW_W(ROW_W), .PEND_MAX(PEND_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_enable(cfg_enable),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .req_row   (req_row),
    .stat_mode (stat_mode),
    .stat_owed (stat_owed)
);

// File: tb/rfsh_sched_test.sv
`timescale 1ns/1ps
module rfsh_sched_test;
    localparam int WIN_W = 24;
    localparam int ROW_W = 14;
    localparam int CAP   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_enable = 1'b0;
    logic             cfg_mode = 1'b0;
    logic [WIN_W-1:0] cfg_window = '0;
    logic [ROW_W-1:0] cfg_rows = '0;
    logic             req_valid;
    logic [ROW_W-1:0] req_row;
    logic             req_ack = 1'b0;
    logic             stat_mode;
    logic [ROW_W-1:0] stat_owed;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    int m_en, m_mode, m_win, m_rows, m_gap, m_cnt, m_owe, m_row;

    always #5 clk = ~clk;

    rfsh_sched #(.WIN_W(WIN_W), .ROW_W(ROW_W), .PEND_MAX(CAP)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_window(cfg_window), .cfg_rows(cfg_rows), .req_valid(req_valid),
        .req_row(req_row), .req_ack(req_ack), .stat_mode(stat_mode), .stat_owed(stat_owed)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int san(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int gap_of(input int w, input int r);
        int g;
        g = san(w) / san(r);
        return (g == 0) ? 1 : g;
    endfunction

    task automatic model_reset();
        m_en = 0; m_mode = 0; m_win = 1; m_rows = 1; m_gap = 1;
        m_cnt = 0; m_owe = 0; m_row = 0;
    endtask

    // one clock: compare outputs with the model, advance the model
    task automatic step();
        int en_in, vld, fire, tick, per, last, n_owe, n_row, n_cnt;
        #1;
        en_in = cfg_enable;
        vld   = (m_en != 0 && en_in != 0 && m_owe != 0) ? 1 : 0;
        chk("R5", "req_valid", req_valid, vld);
        chk("R2", "req_row", req_row, m_row);
        chk("R3", "stat_owed", stat_owed, m_owe);
        chk("R6", "stat_mode", stat_mode, m_mode);
        n_owe = m_owe; n_row = m_row; n_cnt = m_cnt;
        fire  = vld & req_ack;
        last  = (m_row == m_rows - 1) ? 1 : 0;
        if (!en_in) begin
            n_owe = 0; n_cnt = 0;
        end else if (!m_en) begin
            n_row = 0; n_cnt = 0;
            n_owe = (m_mode == 0) ? m_rows : 0;
        end else begin
            per   = m_mode ? m_gap : m_win;
            tick  = (m_cnt >= per - 1) ? 1 : 0;
            n_cnt = tick ? 0 : m_cnt + 1;
            if (fire) n_row = last ? 0 : m_row + 1;
            if (m_mode == 0) begin
                if (tick) n_owe = m_rows;
                else if (fire) n_owe = m_owe - 1;
            end else begin
                if (tick && !fire) n_owe = (m_owe >= CAP) ? m_owe : m_owe + 1;
                else if (fire && !tick) n_owe = m_owe - 1;
            end
        end
        if (!en_in || (fire && last)) begin
            m_mode = cfg_mode; m_win = san(int'(cfg_window));
            m_rows = san(int'(cfg_rows)); m_gap = gap_of(int'(cfg_window), int'(cfg_rows));
        end
        m_en = en_in; m_owe = n_owe; m_row = n_row; m_cnt = n_cnt;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        finish_up();
    end

    initial begin
        int held;
        void'($urandom(32'd5171));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "req_valid", req_valid, 0);
        chk("R1", "req_row", req_row, 0);
        chk("R1", "stat_owed", stat_owed, 0);
        chk("R1", "stat_mode", stat_mode, 0);

        // R2 / R8 burst style, 4 rows, window 20, always acknowledged
        cfg_mode = 1'b0; cfg_window = 20; cfg_rows = 4; req_ack = 1'b1;
        step();                 // settings load while disabled
        cfg_enable = 1'b1;
        step();                 // first enabled cycle
        chk("R8", "owed at enable", stat_owed, 4);
        chk("R8", "row at enable", req_row, 0);
        steps(4);
        chk("R2", "owed after burst", stat_owed, 0);
        chk("R2", "row after burst", req_row, 0);
        steps(16);
        chk("R2", "owed at next window", stat_owed, 4);

        // R3 spread style, window 40 / 4 rows -> gap 10, stalled sequencer
        cfg_enable = 1'b0; req_ack = 1'b0;
        step();
        cfg_mode = 1'b1; cfg_window = 40;
        step();
        cfg_enable = 1'b1;
        step();
        steps(9);
        chk("R3", "owed before gap", stat_owed, 0);
        step();
        chk("R3", "owed after gap", stat_owed, 1);

        // R4 saturation at 8
        steps(100);
        chk("R4", "owed saturated", stat_owed, CAP);
        chk("R5", "held request", req_valid, 1);
        chk("R5", "held row", req_row, 0);

        // R6 change deferred until the last-row acknowledge
        cfg_mode = 1'b0; cfg_window = 100;
        steps(3);
        chk("R6", "mode before wrap", stat_mode, 1);
        req_ack = 1'b1;
        steps(3);
        chk("R6", "mode one row before wrap", stat_mode, 1);
        step();
        chk("R6", "mode after wrap", stat_mode, 0);
        step();
        chk("R5", "row after one ack", req_row, 1);

        // R7 disabled: no request, row held, owed cleared
        cfg_enable = 1'b0;
        steps(5);
        chk("R7", "req_valid off", req_valid, 0);
        chk("R7", "row held", req_row, 1);
        chk("R7", "owed cleared", stat_owed, 0);

        // R8 re-enable restarts at row 0
        cfg_enable = 1'b1;
        step();
        chk("R8", "row restart", req_row, 0);
        chk("R8", "burst owed", stat_owed, 4);

        // R9 zero settings treated as one
        cfg_enable = 1'b0;
        step();
        cfg_mode = 1'b1; cfg_window = 0; cfg_rows = 0;
        step();
        cfg_enable = 1'b1;
        steps(6);
        chk("R9", "single row", req_row, 0);
        chk("R9", "request every cycle", req_valid, 1);

        // seeded random phase
        for (int c = 0; c < 4000; c++) begin
            req_ack = (($urandom % 10) < 7);
            if (($urandom % 150) == 0) begin
                cfg_mode   = $urandom % 2;
                cfg_window = WIN_W'($urandom % 120);
                cfg_rows   = ROW_W'($urandom % 13);
            end
            if (($urandom % 300) == 0) cfg_enable = ~cfg_enable;
            if (!cfg_enable && ($urandom % 8) == 0) cfg_enable = 1'b1;
            held = 0;
            step();
        end
        finish_up();
    end
endmodule